// File: doc/BRIEF.md
# Addressing-Mode Operand Sequencer

This block carries out a two-operand add, `dest = dest + operand`, in which the source operand is fetched through one of nine addressing modes and the destination is always a register. It holds a small register file of its own. A decoded instruction comes in with a one-cycle `start` pulse. That instruction carries a mode code, three register selectors (destination, base, index) and a constant. The block then works through the steps the mode needs. It forms the effective address, issues one or two reads on a single-port memory port and waits for each response. For the auto-stepping modes it writes the stepped base register back, either before or after the access. It writes the sum last.

Each read is a one-cycle request, `mem_rd_en` with `mem_addr`. The response can come any number of cycles later, as a one-cycle `mem_rvalid` with `mem_rdata`. The block raises `done` for exactly one cycle when the instruction retires. In that cycle it shows the value written to the destination on `res_data` and the final value of the base register on `base_data`. A mode code outside the defined set finishes at once with `illegal` set and changes nothing.

Top module: `addr_mode_seq`

## Requirements
- R1: After reset, every register holds zero and `busy`, `done`, `illegal` and `mem_rd_en` are low.
- R2: Mode 0 (register) adds the register named by the base selector to the destination and makes no memory read.
- R3: Mode 1 (immediate) adds the zero-extended constant to the destination and makes no memory read.
- R4: Mode 2 (displacement) makes exactly one read, at base register plus constant, wrapping modulo 2^ADDR_W, and adds the returned word.
- R5: Mode 3 (register indirect) makes exactly one read, at the base register value.
- R6: Mode 4 (indexed) makes exactly one read, at base register plus index register, wrapping modulo 2^ADDR_W.
- R7: Mode 5 (absolute) makes exactly one read, at the constant taken as the address.
- R8: Mode 6 (memory indirect) reads at the base register, then reads again at the word returned, and adds the second word; exactly two reads.
- R9: Mode 7 (auto-increment) reads at the unchanged base register, then adds STEP (default 1) to the base register.
- R10: Mode 8 (auto-decrement) subtracts STEP from the base register first and reads at the decremented value.
- R11: The sum uses the destination value from the start of the instruction. When destination and base are the same register in mode 7 or 8, the sum is written after the step and is the final value.
- R12: Mode codes 9 to 15 assert `illegal` together with `done`, make no read and leave every register unchanged.
- R13: `done` is high for exactly one cycle per accepted instruction, and `busy` is low in the following cycle. Each read request lasts one cycle, and the block waits for its response however late it comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid; accepted when not busy |
| mode | input | 4 | Addressing-mode code |
| dst_sel | input | SEL_W | Destination register |
| base_sel | input | SEL_W | Base (or source) register |
| idx_sel | input | SEL_W | Index register |
| konst | input | CONST_W | Constant: immediate, displacement or absolute address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle retire strobe |
| illegal | output | 1 | Retired instruction had an undefined mode (valid with done) |
| res_data | output | DATA_W | Value written to the destination (valid with done) |
| base_data | output | DATA_W | Final base register value (valid with done) |
| mem_addr | output | ADDR_W | Read address |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid strobe |

## Verification
The bench concentrates on the ordering cases.

- **Auto-decrement.** The bench reads with the base already stepped. A design that read before stepping would request the stale address.
- **Auto-increment.** The bench expects the read at the unstepped base. An update placed too early would shift the address by one.
- **Destination equal to base.** The bench makes the register play both roles. A design that let the base write win, or that summed against the already stepped value, would retire a wrong `res_data`.
- **Memory indirect.** Its second address comes from the first response. Chaining the wrong word, or skipping the second read, shows up in both the address trace and the sum.
- **Wrapping and undefined codes.** Base 0 decremented must wrap to the top of the address space, and a displacement past the top must wrap to the bottom. An undefined mode code must retire with no read and unchanged registers.
- **Response timing.** Response latency varies from read to read, so a design that sampled `mem_rdata` at a fixed cycle would add the wrong word.

// File: rtl/asq_pkg.sv
package asq_pkg;

   typedef enum logic [3:0] {
      M_REG  = 4'd0,
      M_IMM  = 4'd1,
      M_DISP = 4'd2,
      M_RIND = 4'd3,
      M_IDX  = 4'd4,
      M_ABS  = 4'd5,
      M_MIND = 4'd6,
      M_AINC = 4'd7,
      M_ADEC = 4'd8
   } amode_e;

   localparam logic [3:0] MODE_LAST = 4'd8;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_EA   = 3'd1,
      S_MEM1 = 3'd2,
      S_MEM2 = 3'd3,
      S_UPD  = 3'd4,
      S_WB   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/asq_regfile.sv
module asq_regfile #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8,
   parameter int SEL_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  ra_sel,
   input  logic [SEL_W-1:0]  rb_sel,
   input  logic [SEL_W-1:0]  rc_sel,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data,
   output logic [DATA_W-1:0] rc_data,
   input  logic              w0_en,
   input  logic [SEL_W-1:0]  w0_sel,
   input  logic [DATA_W-1:0] w0_data,
   input  logic              w1_en,
   input  logic [SEL_W-1:0]  w1_sel,
   input  logic [DATA_W-1:0] w1_data
);

   if (NREG < 2) begin : g_bad_nreg
      $error("asq_regfile: NREG must be at least 2");
   end
   if ((1 << SEL_W) != NREG) begin : g_bad_sel
      $error("asq_regfile: NREG must equal 2**SEL_W");
   end

   logic [DATA_W-1:0] regs [NREG];

   // Port w1 (result) has priority over port w0 (base step).
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (w1_en && (w1_sel == SEL_W'(i))) begin
            q <= w1_data;
         end else if (w0_en && (w0_sel == SEL_W'(i))) begin
            q <= w0_data;
         end
      end
      assign regs[i] = q;
   end

   assign ra_data = regs[ra_sel];
   assign rb_data = regs[rb_sel];
   assign rc_data = regs[rc_sel];

endmodule

// File: rtl/asq_agu.sv
module asq_agu
   import asq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 16,
   parameter int STEP    = 1
) (
   input  logic [3:0]         mode,
   input  logic [DATA_W-1:0]  base_v,
   input  logic [DATA_W-1:0]  idx_v,
   input  logic [CONST_W-1:0] konst,
   output logic [ADDR_W-1:0]  ea,
   output logic [DATA_W-1:0]  base_inc,
   output logic [DATA_W-1:0]  base_dec
);

   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

   logic [ADDR_W-1:0] base_a, idx_a, k_a, dec_a;

   assign base_inc = base_v + STEP_V;
   assign base_dec = base_v - STEP_V;

   if (ADDR_W == DATA_W) begin : g_addr_full
      assign base_a = base_v;
      assign idx_a  = idx_v;
      assign dec_a  = base_dec;
   end else begin : g_addr_trunc
      assign base_a = base_v[ADDR_W-1:0];
      assign idx_a  = idx_v[ADDR_W-1:0];
      assign dec_a  = base_dec[ADDR_W-1:0];
   end

   if (CONST_W >= ADDR_W) begin : g_k_trunc
      assign k_a = konst[ADDR_W-1:0];
   end else begin : g_k_zext
      assign k_a = {{(ADDR_W-CONST_W){1'b0}}, konst};
   end

   always_comb begin
      case (mode)
         M_DISP:  ea = base_a + k_a;
         M_IDX:   ea = base_a + idx_a;
         M_ABS:   ea = k_a;
         M_ADEC:  ea = dec_a;
         default: ea = base_a;
      endcase
   end

endmodule

// File: rtl/asq_ctrl.sv
module asq_ctrl
   import asq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 16,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode,
   input  logic [SEL_W-1:0]   dst_sel,
   input  logic [SEL_W-1:0]   base_sel,
   input  logic [SEL_W-1:0]   idx_sel,
   input  logic [CONST_W-1:0] konst,
   input  logic [ADDR_W-1:0]  ea_next,
   input  logic [DATA_W-1:0]  base_v,
   input  logic [DATA_W-1:0]  dst_v,
   input  logic [DATA_W-1:0]  base_inc,
   input  logic [DATA_W-1:0]  base_dec,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_rvalid,
   output logic [3:0]         mode_q,
   output logic [SEL_W-1:0]   dst_q,
   output logic [SEL_W-1:0]   base_q,
   output logic [SEL_W-1:0]   idx_q,
   output logic [CONST_W-1:0] k_q,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               busy,
   output logic               done,
   output logic               illegal,
   output logic               bw_en,
   output logic [DATA_W-1:0]  bw_data,
   output logic               dw_en,
   output logic [DATA_W-1:0]  sum
);

   seq_state_e        state;
   logic [ADDR_W-1:0] ea_q;
   logic [DATA_W-1:0] opnd_q, dval_q;
   logic              issued, ill_q;
   logic              in_mem;

   assign in_mem    = (state == S_MEM1) || (state == S_MEM2);
   assign mem_rd_en = in_mem && !issued;
   assign mem_addr  = ea_q;
   assign busy      = (state != S_IDLE);
   assign done      = (state == S_WB);
   assign illegal   = done && ill_q;
   assign sum       = dval_q + opnd_q;
   assign dw_en     = done && !ill_q;
   assign bw_en     = (state == S_UPD);
   assign bw_data   = (mode_q == M_AINC) ? base_inc : base_dec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         mode_q <= '0;
         dst_q  <= '0;
         base_q <= '0;
         idx_q  <= '0;
         k_q    <= '0;
         ea_q   <= '0;
         opnd_q <= '0;
         dval_q <= '0;
         issued <= 1'b0;
         ill_q  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  mode_q <= mode;
                  dst_q  <= dst_sel;
                  base_q <= base_sel;
                  idx_q  <= idx_sel;
                  k_q    <= konst;
                  issued <= 1'b0;
                  ill_q  <= (mode > MODE_LAST);
                  state  <= (mode > MODE_LAST) ? S_WB : S_EA;
               end
            end
            S_EA: begin
               dval_q <= dst_v;
               ea_q   <= ea_next;
               case (mode_q)
                  M_REG: begin
                     opnd_q <= base_v;
                     state  <= S_WB;
                  end
                  M_IMM: begin
                     opnd_q <= DATA_W'(k_q);
                     state  <= S_WB;
                  end
                  M_ADEC:  state <= S_UPD;
                  default: state <= S_MEM1;
               endcase
            end
            S_MEM1: begin
               if (!issued) begin
                  issued <= 1'b1;
               end else if (mem_rvalid) begin
                  issued <= 1'b0;
                  if (mode_q == M_MIND) begin
                     ea_q  <= ADDR_W'(mem_rdata);
                     state <= S_MEM2;
                  end else begin
                     opnd_q <= mem_rdata;
                     state  <= (mode_q == M_AINC) ? S_UPD : S_WB;
                  end
               end
            end
            S_MEM2: begin
               if (!issued) begin
                  issued <= 1'b1;
               end else if (mem_rvalid) begin
                  issued <= 1'b0;
                  opnd_q <= mem_rdata;
                  state  <= S_WB;
               end
            end
            S_UPD: begin
               state <= (mode_q == M_ADEC) ? S_MEM1 : S_WB;
            end
            S_WB: begin
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/addr_mode_seq.sv
module addr_mode_seq #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 16,
   parameter int NREG    = 8,
   parameter int STEP    = 1,
   parameter int SEL_W   = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode,
   input  logic [SEL_W-1:0]   dst_sel,
   input  logic [SEL_W-1:0]   base_sel,
   input  logic [SEL_W-1:0]   idx_sel,
   input  logic [CONST_W-1:0] konst,
   output logic               busy,
   output logic               done,
   output logic               illegal,
   output logic [DATA_W-1:0]  res_data,
   output logic [DATA_W-1:0]  base_data,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd_en,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_rvalid
);

   if (ADDR_W > DATA_W) begin : g_bad_aw
      $error("addr_mode_seq: ADDR_W must not exceed DATA_W");
   end
   if (CONST_W > DATA_W) begin : g_bad_cw
      $error("addr_mode_seq: CONST_W must not exceed DATA_W");
   end
   if (STEP < 1) begin : g_bad_step
      $error("addr_mode_seq: STEP must be positive");
   end

   logic [3:0]         mode_q;
   logic [SEL_W-1:0]   dst_q, base_q, idx_q;
   logic [CONST_W-1:0] k_q;
   logic [DATA_W-1:0]  base_v, idx_v, dst_v;
   logic [DATA_W-1:0]  base_inc, base_dec, bw_data, sum;
   logic [ADDR_W-1:0]  ea_next;
   logic               bw_en, dw_en;

   asq_regfile #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .SEL_W  (SEL_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_sel  (base_q),
      .rb_sel  (idx_q),
      .rc_sel  (dst_q),
      .ra_data (base_v),
      .rb_data (idx_v),
      .rc_data (dst_v),
      .w0_en   (bw_en),
      .w0_sel  (base_q),
      .w0_data (bw_data),
      .w1_en   (dw_en),
      .w1_sel  (dst_q),
      .w1_data (sum)
   );

   asq_agu #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .CONST_W (CONST_W),
      .STEP    (STEP)
   ) u_agu (
      .mode     (mode_q),
      .base_v   (base_v),
      .idx_v    (idx_v),
      .konst    (k_q),
      .ea       (ea_next),
      .base_inc (base_inc),
      .base_dec (base_dec)
   );

   asq_ctrl #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .CONST_W (CONST_W),
      .SEL_W   (SEL_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .dst_sel    (dst_sel),
      .base_sel   (base_sel),
      .idx_sel    (idx_sel),
      .konst      (konst),
      .ea_next    (ea_next),
      .base_v     (base_v),
      .dst_v      (dst_v),
      .base_inc   (base_inc),
      .base_dec   (base_dec),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid),
      .mode_q     (mode_q),
      .dst_q      (dst_q),
      .base_q     (base_q),
      .idx_q      (idx_q),
      .k_q        (k_q),
      .mem_rd_en  (mem_rd_en),
      .mem_addr   (mem_addr),
      .busy       (busy),
      .done       (done),
      .illegal    (illegal),
      .bw_en      (bw_en),
      .bw_data    (bw_data),
      .dw_en      (dw_en),
      .sum        (sum)
   );

   // Retire view: the result write lands after any base step (R11).
   assign res_data  = illegal ? dst_v : sum;
   assign base_data = (!illegal && (dst_q == base_q)) ? sum : base_v;

endmodule

// File: rtl/asq_chk.sv
module asq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [3:0] mode,
   input logic       busy,
   input logic       done,
   input logic       illegal,
   input logic       mem_rd_en
);

   logic [3:0] mode_l;
   logic [2:0] rd_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_l <= '0;
         rd_cnt <= '0;
      end else if (start && !busy) begin
         mode_l <= mode;
         rd_cnt <= '0;
      end else if (mem_rd_en && (rd_cnt != 3'd7)) begin
         rd_cnt <= rd_cnt + 3'd1;
      end
   end

   a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r13_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r13_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r1_rd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   a_r12_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   a_r12_illegal_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (rd_cnt == 3'd0));

   a_r12_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (illegal == (mode_l > 4'd8)));

   a_r2_r3_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (mode_l <= 4'd1)) |-> !mem_rd_en);

   a_r8_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (mode_l == 4'd6)) |-> (rd_cnt == 3'd2));

   a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (mode_l >= 4'd2) && (mode_l <= 4'd8) && (mode_l != 4'd6))
         |-> (rd_cnt == 3'd1));

endmodule

bind addr_mode_seq asq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .busy      (busy),
   .done      (done),
   .illegal   (illegal),
   .mem_rd_en (mem_rd_en)
);

// File: tb/addr_mode_seq_tb.sv
module addr_mode_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [3:0]  mode;
   logic [2:0]  dst_sel, base_sel, idx_sel;
   logic [15:0] konst;
   logic        busy, done, illegal, mem_rd_en, mem_rvalid;
   logic [15:0] res_data, base_data, mem_addr, mem_rdata;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   addr_mode_seq u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .dst_sel    (dst_sel),
      .base_sel   (base_sel),
      .idx_sel    (idx_sel),
      .konst      (konst),
      .busy       (busy),
      .done       (done),
      .illegal    (illegal),
      .res_data   (res_data),
      .base_data  (base_data),
      .mem_addr   (mem_addr),
      .mem_rd_en  (mem_rd_en),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid)
   );

   typedef struct {
      logic [15:0] res;
      logic [15:0] base;
      logic        ill;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [15:0] addr_q[$];
   string       addr_tag_q[$];
   logic [15:0] model[8];

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      return (a * 16'h0123) + 16'h0040;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Memory responder: checks each request address, replies with variable latency.
   initial begin
      int lat_ctr = 0;
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      @(negedge clk);
      forever begin
         if (mem_rd_en) begin
            logic [15:0] a;
            a = mem_addr;
            if (addr_q.size() == 0) begin
               check(1'b0, "R12", "unexpected read", a, 16'h0);
            end else begin
               logic [15:0] ea;
               string t;
               ea = addr_q.pop_front();
               t  = addr_tag_q.pop_front();
               check(a == ea, t, "read address", a, ea);
            end
            repeat ((lat_ctr % 3) + 1) @(negedge clk);
            lat_ctr++;
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word(a);
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata  = 16'hDEAD;
         end else begin
            @(negedge clk);
         end
      end
   end

   // Monitor: pops the scoreboard on every retire.
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R13", "done with empty scoreboard", 16'h0, 16'h0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(res_data == e.res, e.tag, "res_data", res_data, e.res);
               check(base_data == e.base, e.tag, "base_data", base_data, e.base);
               check(illegal == e.ill, e.tag, "illegal", 16'(illegal), 16'(e.ill));
            end
         end
      end
   end

   task automatic run(input logic [3:0] m, input int d, input int b, input int x,
                      input logic [15:0] k, input string tag);
      logic [15:0] ov, bv, xv, a1, opnd;
      bit          ill;
      exp_t        e;
      int          guard;
      ov = model[d];
      bv = model[b];
      xv = model[x];
      ill = (m > 4'd8);
      opnd = '0;
      case (m)
         4'd0: opnd = bv;
         4'd1: opnd = k;
         4'd2: a1 = bv + k;
         4'd3: a1 = bv;
         4'd4: a1 = bv + xv;
         4'd5: a1 = k;
         4'd6: a1 = bv;
         4'd7: a1 = bv;
         4'd8: a1 = bv - 16'd1;
         default: a1 = '0;
      endcase
      if (!ill && m >= 4'd2) begin
         addr_q.push_back(a1);
         addr_tag_q.push_back(tag);
         if (m == 4'd6) begin
            addr_q.push_back(mem_word(a1));
            addr_tag_q.push_back(tag);
            opnd = mem_word(mem_word(a1));
         end else begin
            opnd = mem_word(a1);
         end
      end
      if (!ill) begin
         if (m == 4'd7) model[b] = bv + 16'd1;
         if (m == 4'd8) model[b] = bv - 16'd1;
         model[d] = ov + opnd;
      end
      e.res  = ill ? ov : ov + opnd;
      e.base = ill ? bv : model[b];
      e.ill  = ill;
      e.tag  = tag;
      sb_q.push_back(e);
      @(negedge clk);
      start    = 1'b1;
      mode     = m;
      dst_sel  = 3'(d);
      base_sel = 3'(b);
      idx_sel  = 3'(x);
      konst    = k;
      @(negedge clk);
      start = 1'b0;
      mode  = 4'hF;
      konst = 16'hFFFF;
      guard = 0;
      while (!done && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      check(addr_q.size() == 0, tag, "reads left outstanding",
            16'(addr_q.size()), 16'h0);
      check(!busy && !done, "R13", "idle after retire", 16'(busy), 16'h0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; mode = '0; konst = '0;
      dst_sel = '0; base_sel = '0; idx_sel = '0;
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !illegal && !mem_rd_en, "R1", "reset outputs",
            {12'h0, busy, done, illegal, mem_rd_en}, 16'h0);

      run(4'd1, 5, 5, 0, 16'h0000, "R1");     // reads r5, must be zero
      run(4'd1, 1, 1, 0, 16'h0010, "R3");
      run(4'd1, 2, 2, 0, 16'h0005, "R3");
      run(4'd1, 3, 3, 0, 16'h0100, "R3");
      run(4'd1, 4, 4, 0, 16'h0020, "R3");
      run(4'd0, 1, 2, 0, 16'h7777, "R2");
      run(4'd2, 5, 3, 0, 16'h0004, "R4");
      run(4'd3, 6, 4, 0, 16'h0000, "R5");
      run(4'd4, 5, 3, 2, 16'h0000, "R6");
      run(4'd5, 7, 0, 0, 16'h0033, "R7");
      run(4'd6, 6, 4, 0, 16'h0000, "R8");
      run(4'd7, 5, 4, 0, 16'h0000, "R9");
      run(4'd8, 5, 3, 0, 16'h0000, "R10");
      run(4'd7, 4, 4, 0, 16'h0000, "R11");
      run(4'd8, 3, 3, 0, 16'h0000, "R11");
      run(4'd8, 7, 0, 0, 16'h0000, "R10");    // base 0 wraps to FFFF
      run(4'd2, 6, 0, 0, 16'h0002, "R4");     // FFFF + 2 wraps to 0001
      run(4'd9, 1, 2, 3, 16'h1234, "R12");
      run(4'd15, 4, 4, 0, 16'h0000, "R12");
      run(4'd1, 1, 1, 0, 16'h0000, "R12");    // r1 unchanged by illegal codes
      run(4'd6, 2, 3, 0, 16'h0000, "R8");

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL R13 watchdog: actual=hung expected=retire");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule